// File: doc/BRIEF.md
# Mixed-Kind Register Completer

This block is a small register completer on an APB bus. It holds three 32-bit registers, and each register behaves differently.

- The configuration register keeps whatever software writes to it.
- The status register is only a window onto a hardware input bus. It stores nothing.
- The event register collects hardware interrupt-set pulses. Software clears it by writing ones to the bits it wants to acknowledge.

Any access to an address outside the three mapped offsets finishes with an error response. Such an access changes nothing.

The completer never stretches a transfer. The ready output is always high, so each transfer is one setup cycle followed by one access cycle. Register state changes only at the clock edge that ends a write access phase. Read data and the error flag are driven combinationally during the access phase. Reset is synchronous and active-low.

Top module: `apb_mixreg_slave`

## Requirements
- R1: When `rst_n` is sampled low on a rising clock edge, the configuration register (offset 0x00) and the event register (offset 0x08) both become 0x00000000.
- R2: A write access to offset 0x00 stores the full write data word. A later read of offset 0x00 returns the last value written.
- R3: A read of offset 0x04 returns the value on `hw_status` in that same access cycle. A write to offset 0x04 changes no register.
- R4: A write access to offset 0x08 replaces the event register with old AND NOT write data. For example, 0x0F written with 0x05 gives 0x0A.
- R5: Each bit set on `irq_set` in a cycle sets the matching event-register bit at the next edge. If the same bit is also being cleared by a write in that cycle, the set wins.
- R6: A read or write access to any address other than exactly 0x00, 0x04 or 0x08 completes with `bus_err` high and `bus_rdata` zero, and it changes no register.
- R7: Accesses to mapped offsets complete with `bus_err` low. `bus_err` is low at every time other than an access phase.
- R8: `bus_ready` is always high. Register state changes only when `bus_sel`, `bus_enable` and `bus_write` are all high, so a setup phase on its own changes nothing.
- R9: `bus_rdata` is zero whenever no read access phase is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Completer selected |
| bus_enable | input | 1 | Access phase marker |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_ready | output | 1 | Transfer complete (constant high) |
| bus_err | output | 1 | Error response |
| hw_status | input | 32 | Hardware value seen at offset 0x04 |
| irq_set | input | 32 | Per-bit event set pulses |

## Verification
The assertions assume the requester follows the bus rules: `bus_enable` is never high unless `bus_sel` is high, and address, direction and write data stay stable from setup to access. The bench driver builds every transfer as one setup cycle followed by one access cycle, and it changes these signals only between transfers, a moment after the clock edge. `hw_status` and `irq_set` are assumed to be synchronous to `clk`. The bench drives them only just after rising edges, and it raises an interrupt set in the same access cycle as a clear only to test the set-wins rule.

// File: rtl/mixreg_pkg.sv
`timescale 1ns/1ps
package mixreg_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned OFF_CFG = 'h00;
  localparam int unsigned OFF_STS = 'h04;
  localparam int unsigned OFF_EVT = 'h08;

  typedef logic [REG_W-1:0] word_t;

  typedef enum logic [1:0] {
    PICK_CFG  = 2'd0,
    PICK_STS  = 2'd1,
    PICK_EVT  = 2'd2,
    PICK_NONE = 2'd3
  } reg_pick_e;

  // event register next value: clear by ones, hardware set dominates
  function automatic word_t evt_next(input word_t cur, input word_t clr_mask,
                                     input word_t set_mask);
    word_t kept;
    kept = cur & ~clr_mask;
    return kept | set_mask;
  endfunction
endpackage

// File: rtl/mixreg_decode.sv
`timescale 1ns/1ps
module mixreg_decode
  import mixreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_pick_e         pick,
  output logic              mapped
);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFF_STS);
  localparam logic [ADDR_W-1:0] A_EVT = ADDR_W'(OFF_EVT);

  always_comb begin
    if (addr == A_CFG)      pick = PICK_CFG;
    else if (addr == A_STS) pick = PICK_STS;
    else if (addr == A_EVT) pick = PICK_EVT;
    else                    pick = PICK_NONE;
  end

  assign mapped = (pick != PICK_NONE);
endmodule

// File: rtl/mixreg_regs.sv
`timescale 1ns/1ps
module mixreg_regs
  import mixreg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cfg_wr,
  input  logic  evt_wr,
  input  word_t wdata,
  input  word_t set_bits,
  output word_t cfg_q,
  output word_t evt_q
);
  word_t clr_mask;

  assign clr_mask = evt_wr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_wr) begin
      cfg_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q <= '0;
    end else begin
      evt_q <= evt_next(evt_q, clr_mask, set_bits);
    end
  end
endmodule

// File: rtl/mixreg_rdmux.sv
`timescale 1ns/1ps
module mixreg_rdmux
  import mixreg_pkg::*;
(
  input  logic      rd_act,
  input  reg_pick_e pick,
  input  word_t     cfg_q,
  input  word_t     sts_in,
  input  word_t     evt_q,
  output word_t     rdata
);
  always_comb begin
    rdata = '0;
    if (rd_act) begin
      unique case (pick)
        PICK_CFG:  rdata = cfg_q;
        PICK_STS:  rdata = sts_in;
        PICK_EVT:  rdata = evt_q;
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/apb_mixreg_slave.sv
`timescale 1ns/1ps
module apb_mixreg_slave
  import mixreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_enable,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              bus_ready,
  output logic              bus_err,
  input  logic [REG_W-1:0]  hw_status,
  input  logic [REG_W-1:0]  irq_set
);
  // named internal events, visible to the bound checker
  reg_pick_e pick;
  logic      mapped;
  logic      acc_ev;
  logic      wr_ev;
  logic      rd_ev;
  logic      cfg_wr_ev;
  logic      evt_wr_ev;
  word_t     cfg_q;
  word_t     evt_q;

  mixreg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (bus_addr),
    .pick   (pick),
    .mapped (mapped)
  );

  assign acc_ev    = bus_sel & bus_enable;
  assign wr_ev     = acc_ev & bus_write;
  assign rd_ev     = acc_ev & ~bus_write;
  assign cfg_wr_ev = wr_ev & (pick == PICK_CFG);
  assign evt_wr_ev = wr_ev & (pick == PICK_EVT);

  mixreg_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr_ev),
    .evt_wr   (evt_wr_ev),
    .wdata    (bus_wdata),
    .set_bits (irq_set),
    .cfg_q    (cfg_q),
    .evt_q    (evt_q)
  );

  mixreg_rdmux u_mux (
    .rd_act (rd_ev),
    .pick   (pick),
    .cfg_q  (cfg_q),
    .sts_in (hw_status),
    .evt_q  (evt_q),
    .rdata  (bus_rdata)
  );

  assign bus_ready = 1'b1;
  assign bus_err   = acc_ev & ~mapped;
endmodule

// File: rtl/mixreg_checker.sv
`timescale 1ns/1ps
module mixreg_checker
  import mixreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_enable,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  bus_rdata,
  input logic              bus_err,
  input logic [REG_W-1:0]  hw_status,
  input logic [REG_W-1:0]  irq_set,
  input logic [REG_W-1:0]  cfg_q,
  input logic [REG_W-1:0]  evt_q
);
  logic armed;
  logic acc, is_cfg, is_sts, is_evt, known;

  always_ff @(posedge clk) armed <= rst_n;

  assign acc    = bus_sel & bus_enable;
  assign is_cfg = (bus_addr == ADDR_W'(OFF_CFG));
  assign is_sts = (bus_addr == ADDR_W'(OFF_STS));
  assign is_evt = (bus_addr == ADDR_W'(OFF_EVT));
  assign known  = is_cfg | is_sts | is_evt;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (cfg_q == '0 && evt_q == '0)); // R1

  AST_CFG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (acc && bus_write && is_cfg) |=> cfg_q == $past(bus_wdata)); // R2

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !(acc && bus_write && is_cfg) |=> $stable(cfg_q)); // R8

  AST_STS_LIVE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (acc && !bus_write && is_sts) |-> bus_rdata == hw_status); // R3

  AST_EVT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (acc && bus_write && is_evt) |=> ((evt_q & $past(bus_wdata) & ~$past(irq_set)) == '0)); // R4

  AST_EVT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (irq_set != '0) |=> ((evt_q & $past(irq_set)) == $past(irq_set))); // R5

  AST_UNMAPPED_ERR: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (acc && !known) |-> (bus_err && bus_rdata == '0)); // R6

  AST_ERR_ONLY_ACCESS: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !(acc && !known) |-> !bus_err); // R7

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !(acc && !bus_write) |-> bus_rdata == '0); // R9
endmodule

bind apb_mixreg_slave mixreg_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_enable (bus_enable),
  .bus_write  (bus_write),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_err    (bus_err),
  .hw_status  (hw_status),
  .irq_set    (irq_set),
  .cfg_q      (cfg_q),
  .evt_q      (evt_q)
);

// File: tb/apb_mixreg_slave_bench.sv
`timescale 1ns/1ps
module apb_mixreg_slave_bench;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b0, en = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0, rdata, hw_st = '0, set_in = '0;
  logic          ready, err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // scoreboard queues: one entry per access phase
  logic [31:0] q_data[$];
  logic        q_err[$];
  string       q_tag[$];

  // bench-side register model
  logic [31:0] m_cfg = '0;
  logic [31:0] m_evt = '0;

  always #5 clk = ~clk;

  apb_mixreg_slave #(.ADDR_W(AW)) u_apb_mixreg_slave (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_enable(en), .bus_write(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .bus_ready(ready),
    .bus_err(err), .hw_status(hw_st), .irq_set(set_in)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares at the falling edge
  always @(negedge clk) begin
    if (rst_n && sel && en) begin
      if (q_tag.size() == 0) begin
        check(1'b0, "scoreboard underflow", 64'd0, 64'd1);
      end else begin
        logic [31:0] ed;
        logic        ee;
        string       t;
        ed = q_data.pop_front();
        ee = q_err.pop_front();
        t  = q_tag.pop_front();
        check(rdata === ed, {t, " rdata"}, 64'(rdata), 64'(ed));
        check(err === ee, {t, " err"}, 64'(err), 64'(ee));
        check(ready === 1'b1, "R8 ready", 64'(ready), 64'd1);
      end
    end else if (rst_n && sel && !en) begin
      check(rdata === 32'd0, "R9 rdata in setup", 64'(rdata), 64'd0);
      check(err === 1'b0, "R7 err in setup", 64'(err), 64'd0);
    end
  end

  function automatic bit is_known(input logic [AW-1:0] a);
    return (a == 12'h000) || (a == 12'h004) || (a == 12'h008);
  endfunction

  // driver: one setup cycle, one access cycle; set_mask is raised during access
  task automatic xfer(input bit w, input logic [AW-1:0] a, input logic [31:0] d,
                      input logic [31:0] set_mask, input string tag);
    logic [31:0] exp_d;
    exp_d = 32'd0;
    if (!w) begin
      if (a == 12'h000)      exp_d = m_cfg;
      else if (a == 12'h004) exp_d = hw_st;
      else if (a == 12'h008) exp_d = m_evt;
    end
    q_data.push_back(exp_d);
    q_err.push_back(!is_known(a));
    q_tag.push_back(tag);
    @(posedge clk); #1;
    sel = 1'b1; en = 1'b0; wr = w; addr = a; wdata = d;
    @(posedge clk); #1;
    en = 1'b1; set_in = set_mask;
    @(posedge clk); #1;
    sel = 1'b0; en = 1'b0; wr = 1'b0; set_in = '0;
    // model update, written as per-bit reasoning
    for (int b = 0; b < 32; b++) begin
      if (set_mask[b]) m_evt[b] = 1'b1;
      else if (w && a == 12'h008 && d[b]) m_evt[b] = 1'b0;
    end
    if (w && a == 12'h000) m_cfg = d;
  endtask

  task automatic pulse_set(input logic [31:0] m);
    @(posedge clk); #1; set_in = m;
    @(posedge clk); #1; set_in = '0;
    m_evt = m_evt | m;
  endtask

  task automatic do_reset();
    @(posedge clk); #1; rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1; rst_n = 1'b1;
    m_cfg = '0; m_evt = '0;
  endtask

  initial begin
    do_reset();
    // R1: reset state
    xfer(0, 12'h000, 0, 0, "R1 cfg after reset");
    xfer(0, 12'h008, 0, 0, "R1 evt after reset");
    // R2: read-back
    xfer(1, 12'h000, 32'hA5A5_1234, 0, "R2 cfg write");
    xfer(0, 12'h000, 0, 0, "R2 cfg readback");
    xfer(1, 12'h000, 32'hFFFF_0001, 0, "R2 cfg rewrite");
    xfer(0, 12'h000, 0, 0, "R2 cfg readback2");
    // R3: live status, writes ignored
    hw_st = 32'h0000_0001;
    xfer(1, 12'h004, 32'h0000_00AA, 0, "R3 sts write");
    xfer(0, 12'h004, 0, 0, "R3 sts read");
    xfer(0, 12'h000, 0, 0, "R3 cfg untouched");
    xfer(0, 12'h008, 0, 0, "R3 evt untouched");
    hw_st = 32'hDEAD_BEEF;
    xfer(0, 12'h004, 0, 0, "R3 sts follows hw");
    // R5/R4: set then clear by ones
    pulse_set(32'h0000_000F);
    xfer(0, 12'h008, 0, 0, "R5 evt set");
    xfer(1, 12'h008, 32'h0000_0005, 0, "R4 evt clr 05");
    xfer(0, 12'h008, 0, 0, "R4 evt is 0A");
    xfer(1, 12'h008, 32'h0000_000A, 0, "R4 evt clr 0A");
    xfer(0, 12'h008, 0, 0, "R4 evt is 0");
    // R5: set wins over same-cycle clear
    pulse_set(32'h8000_000F);
    xfer(1, 12'h008, 32'h8000_0003, 32'h8000_0001, "R5 set vs clr");
    xfer(0, 12'h008, 0, 0, "R5 set won");
    // R6: unmapped accesses
    xfer(0, 12'h00C, 0, 0, "R6 unmapped read");
    xfer(1, 12'h010, 32'h1234_5678, 0, "R6 unmapped write");
    xfer(1, 12'h001, 32'h0BAD_0BAD, 0, "R6 misaligned write");
    xfer(0, 12'hFF0, 0, 0, "R6 high read");
    xfer(0, 12'h000, 0, 0, "R6 cfg unchanged");
    xfer(0, 12'h008, 0, 0, "R6 evt unchanged");
    // R8: setup phase alone does not write
    @(posedge clk); #1;
    sel = 1; en = 0; wr = 1; addr = 12'h000; wdata = 32'h7777_7777;
    @(posedge clk); #1;
    sel = 0; wr = 0;
    xfer(0, 12'h000, 0, 0, "R8 setup only");
    // R7: idle err low, R9 idle rdata zero
    @(negedge clk);
    check(err === 1'b0, "R7 idle err", 64'(err), 64'd0);
    check(rdata === 32'd0, "R9 idle rdata", 64'(rdata), 64'd0);
    // R1: reset mid-run
    do_reset();
    xfer(0, 12'h000, 0, 0, "R1 cfg after rerun reset");
    xfer(0, 12'h008, 0, 0, "R1 evt after rerun reset");
    repeat (2) @(posedge clk);
    check(q_tag.size() == 0, "scoreboard drained", 64'(q_tag.size()), 64'd0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule